// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block is one 8-bit control and status register for a real-time clock. Software writes it and reads it back through a plain write strobe and read-data bus. It holds a supply-monitor threshold select, a sticky low-voltage flag, a scratch bit, a sticky oscillator-halt flag, an active-low clock-enable bit and three event flags.

Two external sense circuits feed it. A supply-voltage comparator reports low voltage, and an oscillation-halt detector reports that the crystal stopped. The register drives the comparator's threshold select and its enable.

The flags are sticky. Software can only clear them, by writing 0 to their bit. A low-voltage flag that is set switches its own monitor off. A halt flag that is set pins the whole register at its default value until software clears it.

The port is a register interface, not a stream. A write is accepted in the cycle its strobe is high, with no back-pressure, and `rd_data` always shows the current register value.

Top module: `rtc_csr`

## Requirements
- R1: After reset, `rd_data` is 0x10, `mon_en` is 1 and `thr_low` is 0. The bit layout from bit 7 down to bit 0 is:
  - threshold select
  - low-voltage flag
  - scratch
  - halt flag
  - clock-enable (active low)
  - event flag C, event flag B, event flag A
- R2: A `halt_evt` pulse while `chip_en` is 0 makes `rd_data` read 0x10 in the next cycle. This takes priority over a write in the same cycle, including a write that clears the halt flag.
- R3: A `halt_evt` pulse while `chip_en` is 1 has no effect on the register.
- R4: While bit 4 is 1 and no write with bit 4 = 0 occurs, the register stays at 0x10. Other writes, event pulses and `lowv_evt` are ignored.
- R5: A write with bit 4 = 0 clears the halt flag. The same write loads bits 7, 5 and 3 from `wr_data`, and its event inputs apply.
- R6: `thr_low` equals register bit 7. It changes in the cycle after the write that changes that bit.
- R7: `lowv_evt` while `mon_en` is 1 sets bit 6 in the next cycle, and `mon_en` reads 0 while bit 6 is 1. While bit 6 is 1, `lowv_evt` is ignored and writing 1 to bit 6 changes nothing.
- R8: A write with bit 6 = 0 clears the low-voltage flag, and `mon_en` returns to 1 in the next cycle.
- R9: A pulse on `evt[i]` sets bit i (i = 0..2) in the next cycle. A write with bit i = 0 clears it, and a write with bit i = 1 leaves it unchanged.
- R10: When `evt[i]` pulses in the same cycle as a write with bit i = 0, bit i ends up 1.
- R11: Bit 5 follows writes and is forced to 0 when the halt flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| chip_en | input | 1 | Chip enable; halt sensing only while 0 |
| halt_evt | input | 1 | Oscillation-halt detector pulse |
| lowv_evt | input | 1 | Supply comparator low-voltage pulse |
| evt | input | 3 | Event pulses for flags in bits 2..0 |
| thr_low | output | 1 | Monitor threshold select (1 = lower) |
| mon_en | output | 1 | Supply monitor enable |

## Verification
The bench first writes all ones to show that 1-writes to the flag, halt and low-voltage bits do nothing. Selective zero-writes then show that each flag is cleared on its own, and that the other flags are not disturbed.

Event pulses that land in the same cycle as clearing writes separate the set-wins priority from plain clearing. Halt pulses with chip enable high and with chip enable low separate masking from default reload.

Writes and events applied while the halt flag is set show that the register is pinned at its default. A final clearing write shows that the bits carried in that same write are loaded.

// File: rtl/rtc_csr_pkg.sv
package rtc_csr_pkg;
  localparam int unsigned CSR_W    = 8;
  localparam int unsigned N_EVT    = 3;
  localparam int unsigned B_THR    = 7;
  localparam int unsigned B_LOWV   = 6;
  localparam int unsigned B_SCR    = 5;
  localparam int unsigned B_HALT   = 4;
  localparam int unsigned B_CKEN_N = 3;
  localparam logic [CSR_W-1:0] CSR_DFLT = 8'h10;
endpackage

// File: rtl/rtc_sticky_bit.sv
// Flag that is set by an event, cleared by a request and forced to its
// default by a reload; set has priority over clear.
module rtc_sticky_bit #(
  parameter logic DFLT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= DFLT;
    else if (reload) q <= DFLT;
    else if (set_i)  q <= 1'b1;
    else if (clr_i)  q <= 1'b0;
  end
endmodule

// File: rtl/rtc_halt_ctl.sv
// Halt flag and the default-reload request that it drives.
module rtc_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_evt,
  input  logic chip_en,
  input  logic wr_en,
  input  logic wr_halt_bit,
  output logic halt_q,
  output logic reload
);
  logic halt_hit;
  logic halt_clr;

  assign halt_hit = halt_evt & ~chip_en;
  assign halt_clr = wr_en & ~wr_halt_bit;
  // Reload on a fresh halt, or keep reloading while the flag stays set.
  assign reload   = halt_hit | (halt_q & ~halt_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halt_q <= 1'b1;
    else if (halt_hit) halt_q <= 1'b1;
    else if (halt_clr) halt_q <= 1'b0;
  end
endmodule

// File: rtl/rtc_csr.sv
module rtc_csr
  import rtc_csr_pkg::*;
#(
  parameter int unsigned NE = N_EVT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wr_data,
  output logic [CSR_W-1:0]  rd_data,
  input  logic              chip_en,
  input  logic              halt_evt,
  input  logic              lowv_evt,
  input  logic [NE-1:0]     evt,
  output logic              thr_low,
  output logic              mon_en
);
  logic          halt_q;
  logic          reload;
  logic          lowv_q;
  logic          thr_q;
  logic          scr_q;
  logic          cken_n_q;
  logic [NE-1:0] flag_q;

  rtc_halt_ctl u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_evt    (halt_evt),
    .chip_en     (chip_en),
    .wr_en       (wr_en),
    .wr_halt_bit (wr_data[B_HALT]),
    .halt_q      (halt_q),
    .reload      (reload)
  );

  // Low-voltage flag: the monitor is off while it is set, so only a
  // monitored event can set it.
  rtc_sticky_bit #(.DFLT(CSR_DFLT[B_LOWV])) u_lowv (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload),
    .set_i  (lowv_evt & mon_en),
    .clr_i  (wr_en & ~wr_data[B_LOWV]),
    .q      (lowv_q)
  );

  for (genvar i = 0; i < NE; i++) begin : g_flag
    rtc_sticky_bit #(.DFLT(CSR_DFLT[i])) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (reload),
      .set_i  (evt[i]),
      .clr_i  (wr_en & ~wr_data[i]),
      .q      (flag_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q    <= CSR_DFLT[B_THR];
      scr_q    <= CSR_DFLT[B_SCR];
      cken_n_q <= CSR_DFLT[B_CKEN_N];
    end else if (reload) begin
      thr_q    <= CSR_DFLT[B_THR];
      scr_q    <= CSR_DFLT[B_SCR];
      cken_n_q <= CSR_DFLT[B_CKEN_N];
    end else if (wr_en) begin
      thr_q    <= wr_data[B_THR];
      scr_q    <= wr_data[B_SCR];
      cken_n_q <= wr_data[B_CKEN_N];
    end
  end

  assign rd_data = {thr_q, lowv_q, scr_q, halt_q, cken_n_q, flag_q};
  assign thr_low = thr_q;
  assign mon_en  = ~lowv_q;
endmodule

// File: rtl/rtc_csr_chk.sv
module rtc_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       chip_en,
  input logic       halt_evt,
  input logic       lowv_evt,
  input logic [2:0] evt,
  input logic       mon_en
);
  AST_HALT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_evt && !chip_en) |=> (rd_data == 8'h10)); // R2
  AST_HALT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_evt && chip_en && !rd_data[4]) |=> !rd_data[4]); // R3
  AST_HALT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && !(wr_en && !wr_data[4])) |=> (rd_data == 8'h10)); // R4
  AST_LOWV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6] && !(wr_en && !wr_data[6]) && !(halt_evt && !chip_en)) |=> (rd_data[6] && !mon_en)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && !rd_data[4] && !(halt_evt && !chip_en)) |=> rd_data[0]); // R10
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:0] == 3'b000 && evt == 3'b000) |=> (rd_data[2:0] == 3'b000)); // R9
endmodule

bind rtc_csr rtc_csr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .chip_en  (chip_en),
  .halt_evt (halt_evt),
  .lowv_evt (lowv_evt),
  .evt      (evt),
  .mon_en   (mon_en)
);

// File: tb/tb_rtc_csr.sv
`timescale 1ns/1ps
module tb_rtc_csr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       chip_en = 1'b0;
  logic       halt_evt = 1'b0;
  logic       lowv_evt = 1'b0;
  logic [2:0] evt = 3'b000;
  logic       thr_low;
  logic       mon_en;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [7:0] rd;
    logic       mon;
    logic       thr;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  rtc_csr dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .chip_en(chip_en), .halt_evt(halt_evt),
    .lowv_evt(lowv_evt), .evt(evt), .thr_low(thr_low), .mon_en(mon_en)
  );

  task automatic check(input logic [7:0] rd, input logic mon, input logic thr, input string tag);
    checks++;
    if (rd_data !== rd || mon_en !== mon || thr_low !== thr) begin
      fails++;
      $display("FAIL %s: rd=%h mon=%b thr=%b expected rd=%h mon=%b thr=%b",
               tag, rd_data, mon_en, thr_low, rd, mon, thr);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic op(input logic we, input logic [7:0] wd, input logic ce,
                    input logic lv, input logic hv, input logic [2:0] ev,
                    input logic [7:0] exp_rd, input logic exp_mon, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = wd; chip_en = ce;
    lowv_evt = lv; halt_evt = hv; evt = ev;
    e.rd = exp_rd; e.mon = exp_mon; e.thr = exp_rd[7]; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: after each edge, compares the result of the last stimulus.
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.rd, e.mon, e.thr, e.tag);
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: rd=%h expected run to finish", rd_data);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(8'h10, 1'b1, 1'b0, "R1 reset value");
    op(1, 8'hA8, 0, 0, 0, 3'b000, 8'hA8, 1, "R5 R6 clear halt and load bits");
    op(1, 8'hFF, 0, 0, 0, 3'b000, 8'hA8, 1, "R9 R7 one-writes ignored");
    op(0, 8'h00, 0, 0, 0, 3'b111, 8'hAF, 1, "R9 event set");
    op(1, 8'hAD, 0, 0, 0, 3'b000, 8'hAD, 1, "R9 selective clear");
    op(1, 8'hA8, 0, 0, 0, 3'b001, 8'hA9, 1, "R10 set wins over clear");
    op(0, 8'h00, 0, 1, 0, 3'b000, 8'hE9, 0, "R7 low voltage sets flag");
    op(1, 8'hE9, 0, 1, 0, 3'b000, 8'hE9, 0, "R7 sticky and write1 ignored");
    op(1, 8'h29, 0, 0, 0, 3'b000, 8'h29, 1, "R8 R6 clear low voltage");
    op(0, 8'h00, 1, 0, 1, 3'b000, 8'h29, 1, "R3 halt masked by chip_en");
    op(1, 8'h29, 0, 0, 1, 3'b000, 8'h10, 1, "R2 R11 halt reload scratch cleared");
    op(1, 8'hB0, 0, 0, 0, 3'b000, 8'h10, 1, "R4 write ignored while halted");
    op(0, 8'h00, 0, 1, 0, 3'b111, 8'h10, 1, "R4 events ignored while halted");
    op(1, 8'h20, 0, 0, 0, 3'b010, 8'h22, 1, "R5 R11 clear halt with scratch and event");
    op(1, 8'h02, 0, 0, 1, 3'b000, 8'h10, 1, "R2 halt beats clearing write");
    op(0, 8'h00, 0, 0, 0, 3'b000, 8'h10, 1, "R4 idle while halted");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule